// File: doc/BRIEF.md
# Epoch-Aware Persistent Write Scheduler

This block holds pending write-backs headed for a banked non-volatile memory and decides, every cycle, which of them go to which bank. Each write carries an address, a target bank and a class bit: persistent or volatile. A barrier pulse closes the current epoch. Persistent writes are strictly ordered across epochs. Volatile writes ignore barriers, so they can fill a bank that would otherwise idle while the persistent part of an older epoch drains.

Every bank has its own issue lane. In one cycle, a lane can issue one write if the bank is not busy and has no write of its own outstanding. A write stays in the queue from enqueue until its bank signals completion, and it counts toward the full flag for that whole time. While the flag is high, upstream eviction must stall.

Top module: `pws_sched`

## Requirements
- R1: After reset the queue is empty, `enq_full` is low and no lane issues.
- R2: `enq_full` is high exactly when DEPTH entries are held, counting both waiting and outstanding entries. An enqueue presented while `enq_full` is high is dropped and is never issued.
- R3: Lane b issues only for bank b. It never issues while `bank_busy[b]` is high, and it never issues while bank b already has an outstanding write. Bank b therefore has at most one write in flight, while different banks may be busy at once.
- R4: A persistent write (`enq_vol`=0) from a later epoch does not issue until every persistent write of all earlier epochs has completed.
- R5: A volatile write (`enq_vol`=1) from a later epoch may issue before the persistent writes of earlier epochs complete. It does so only when its bank is free and that bank has no eligible write of the current epoch.
- R6: When a persistent and a volatile write are both eligible for the same free bank, the persistent one is issued, even if it is younger.
- R7: Among eligible writes of one bank and one class, the oldest is issued first.
- R8: Two writes to the same address issue in arrival order, whatever their classes.
- R9: A barrier sent while no persistent write is pending adds no delay. An entry enqueued in the same cycle as a barrier belongs to the epoch before that barrier.
- R10: A `cpl[b]` pulse retires the outstanding write of bank b. This frees its queue slot and lets the bank take a new write two cycles after its issue at the earliest. Each issue reports the entry's address on `iss_addr[b]` and its class on `iss_vol[b]` (1 = volatile).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enq_valid | input | 1 | Enqueue request |
| enq_addr | input | ADDR_W | Write address |
| enq_bank | input | BANK_W | Target bank |
| enq_vol | input | 1 | 1 = volatile, 0 = persistent |
| enq_full | output | 1 | Queue full; enqueue refused |
| barrier | input | 1 | Persistence barrier pulse |
| bank_busy | input | NBANK | Bank cannot accept a write this cycle |
| cpl | input | NBANK | Completion pulse per bank |
| iss_valid | output | NBANK | Issue strobe per bank lane |
| iss_addr | output | NBANK x ADDR_W | Address of the issued write per lane |
| iss_vol | output | NBANK | Class of the issued write per lane |

## Verification
The checks assume two things about the inputs. First, `cpl[b]` pulses only for a bank that has a write outstanding. Second, barriers never leave more than 2^EPOCH_W−1 epochs open, because the epoch tags wrap and comparing them needs that window. The bench meets both: it completes only lanes it has observed issuing, and it sends only a handful of barriers, each after the earlier persistent writes have drained or with at most one epoch open. `bank_busy` is treated as a free input, so the issue checks hold for any pattern of it.

// File: rtl/pws_pkg.sv
package pws_pkg;
    // Arbitration classes, highest priority first
    typedef enum logic [1:0] {
        CLS_PERS  = 2'd0,
        CLS_VCUR  = 2'd1,
        CLS_VLATE = 2'd2
    } pws_cls_e;

    localparam int NUM_CLS = 3;
endpackage

// File: rtl/pws_oldest.sv
// Grants the single oldest requester; older[i][j] set means j arrived before i.
module pws_oldest #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0]            req,
    input  logic [DEPTH-1:0][DEPTH-1:0] older,
    output logic [DEPTH-1:0]            gnt
);
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            gnt[i] = req[i] && !(|(req & older[i]));
        end
    end
endmodule

// File: rtl/pws_bank_pick.sv
// Per-bank selection: class priority first, then age within the class.
module pws_bank_pick
    import pws_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic [NUM_CLS-1:0][DEPTH-1:0] req,
    input  logic [DEPTH-1:0][DEPTH-1:0]   older,
    output logic [DEPTH-1:0]              gnt,
    output logic                          any,
    output logic                          vol
);
    logic [NUM_CLS-1:0][DEPTH-1:0] cls_gnt;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        pws_oldest #(.DEPTH(DEPTH)) u_old (
            .req   (req[c]),
            .older (older),
            .gnt   (cls_gnt[c])
        );
    end

    always_comb begin
        gnt = '0;
        vol = 1'b0;
        if (|req[CLS_PERS]) begin
            gnt = cls_gnt[CLS_PERS];
        end else if (|req[CLS_VCUR]) begin
            gnt = cls_gnt[CLS_VCUR];
            vol = 1'b1;
        end else if (|req[CLS_VLATE]) begin
            gnt = cls_gnt[CLS_VLATE];
            vol = 1'b1;
        end
        any = |gnt;
    end
endmodule

// File: rtl/pws_sched.sv
module pws_sched
    import pws_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int NBANK   = 4,
    parameter int ADDR_W  = 16,
    parameter int EPOCH_W = 3,
    parameter int BANK_W  = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          enq_valid,
    input  logic [ADDR_W-1:0]             enq_addr,
    input  logic [BANK_W-1:0]             enq_bank,
    input  logic                          enq_vol,
    output logic                          enq_full,
    input  logic                          barrier,
    input  logic [NBANK-1:0]              bank_busy,
    input  logic [NBANK-1:0]              cpl,
    output logic [NBANK-1:0]              iss_valid,
    output logic [NBANK-1:0][ADDR_W-1:0]  iss_addr,
    output logic [NBANK-1:0]              iss_vol
);
    typedef struct packed {
        logic [DEPTH-1:0]               vld;
        logic [DEPTH-1:0]               iss;
        logic [DEPTH-1:0]               vol;
        logic [DEPTH-1:0][EPOCH_W-1:0]  ep;
        logic [DEPTH-1:0][BANK_W-1:0]   bk;
        logic [DEPTH-1:0][ADDR_W-1:0]   ad;
        logic [DEPTH-1:0][DEPTH-1:0]    older;
        logic [EPOCH_W-1:0]             cur;
        logic [EPOCH_W-1:0]             tail;
    } st_t;

    st_t st_q, st_d;

    logic                                   adv;
    logic [EPOCH_W-1:0]                     cur_eff;
    logic [DEPTH-1:0]                       cand;
    logic [DEPTH-1:0]                       is_cur;
    logic [NBANK-1:0]                       bank_free;
    logic [NBANK-1:0][NUM_CLS-1:0][DEPTH-1:0] req;
    logic [NBANK-1:0][DEPTH-1:0]            gnt;

    // ---------------------------------------------------------------
    // Eligibility decode
    // ---------------------------------------------------------------
    always_comb begin
        logic pend_pers;
        logic haz;
        logic outst;
        pend_pers = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (st_q.vld[i] && !st_q.vol[i] && st_q.ep[i] == st_q.cur) begin
                pend_pers = 1'b1;
            end
        end
        adv     = (st_q.cur != st_q.tail) && !pend_pers;
        cur_eff = adv ? st_q.cur + EPOCH_W'(1) : st_q.cur;

        for (int i = 0; i < DEPTH; i++) begin
            haz = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                if (st_q.vld[j] && !st_q.iss[j] && st_q.older[i][j] &&
                    st_q.ad[j] == st_q.ad[i]) begin
                    haz = 1'b1;
                end
            end
            cand[i]   = st_q.vld[i] && !st_q.iss[i] && !haz;
            is_cur[i] = (st_q.ep[i] == cur_eff) || (adv && st_q.ep[i] == st_q.cur);
        end

        for (int b = 0; b < NBANK; b++) begin
            outst = 1'b0;
            for (int i = 0; i < DEPTH; i++) begin
                if (st_q.vld[i] && st_q.iss[i] && st_q.bk[i] == BANK_W'(b)) begin
                    outst = 1'b1;
                end
            end
            bank_free[b] = !bank_busy[b] && !outst;
            for (int i = 0; i < DEPTH; i++) begin
                logic mine;
                mine = cand[i] && bank_free[b] && st_q.bk[i] == BANK_W'(b);
                req[b][CLS_PERS][i]  = mine && !st_q.vol[i] && st_q.ep[i] == cur_eff;
                req[b][CLS_VCUR][i]  = mine &&  st_q.vol[i] && is_cur[i];
                req[b][CLS_VLATE][i] = mine &&  st_q.vol[i] && !is_cur[i];
            end
        end
    end

    // ---------------------------------------------------------------
    // Per-bank arbitration
    // ---------------------------------------------------------------
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        pws_bank_pick #(.DEPTH(DEPTH)) u_pick (
            .req   (req[b]),
            .older (st_q.older),
            .gnt   (gnt[b]),
            .any   (iss_valid[b]),
            .vol   (iss_vol[b])
        );
    end

    always_comb begin
        for (int b = 0; b < NBANK; b++) begin
            iss_addr[b] = '0;
            for (int i = 0; i < DEPTH; i++) begin
                if (gnt[b][i]) begin
                    iss_addr[b] = iss_addr[b] | st_q.ad[i];
                end
            end
        end
    end

    assign enq_full = &st_q.vld;

    // ---------------------------------------------------------------
    // Next state
    // ---------------------------------------------------------------
    always_comb begin
        int slot;
        st_d = st_q;
        slot = 0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.vld[i]) begin
                slot = i;
            end
        end

        for (int i = 0; i < DEPTH; i++) begin
            for (int b = 0; b < NBANK; b++) begin
                if (gnt[b][i]) begin
                    st_d.iss[i] = 1'b1;
                end
            end
            if (st_q.vld[i] && st_q.iss[i] && cpl[st_q.bk[i]]) begin
                st_d.vld[i] = 1'b0;
                st_d.iss[i] = 1'b0;
            end
            // volatile stragglers travel with the current epoch
            if (adv && st_q.vld[i] && st_q.vol[i] && st_q.ep[i] == st_q.cur) begin
                st_d.ep[i] = cur_eff;
            end
        end

        if (enq_valid && !enq_full) begin
            st_d.vld[slot]   = 1'b1;
            st_d.iss[slot]   = 1'b0;
            st_d.vol[slot]   = enq_vol;
            st_d.ep[slot]    = st_q.tail;
            st_d.bk[slot]    = enq_bank;
            st_d.ad[slot]    = enq_addr;
            st_d.older[slot] = st_q.vld;
            for (int j = 0; j < DEPTH; j++) begin
                st_d.older[j][slot] = 1'b0;
            end
        end

        st_d.tail = st_q.tail + EPOCH_W'(barrier);
        st_d.cur  = cur_eff;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/pws_sched_chk.sv
module pws_sched_chk #(
    parameter int DEPTH   = 8,
    parameter int NBANK   = 4,
    parameter int EPOCH_W = 3
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enq_valid,
    input logic               enq_full,
    input logic               barrier,
    input logic [NBANK-1:0]   bank_busy,
    input logic [NBANK-1:0]   cpl,
    input logic [NBANK-1:0]   iss_valid,
    input logic [EPOCH_W-1:0] cur,
    input logic [EPOCH_W-1:0] tail
);
    localparam int CNT_W = $clog2(DEPTH + 1) + 1;
    localparam logic [EPOCH_W-1:0] EP_LAST = '1;

    logic [CNT_W-1:0] cnt_q;
    logic [NBANK-1:0] outst_q;
    logic [EPOCH_W-1:0] open_ep;

    assign open_ep = tail - cur;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            outst_q <= '0;
        end else begin
            cnt_q   <= cnt_q + CNT_W'(enq_valid && !enq_full)
                             - CNT_W'($countones(cpl & outst_q));
            outst_q <= (outst_q & ~cpl) | iss_valid;
        end
    end

    p_full_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        enq_full == (cnt_q == CNT_W'(DEPTH)));

    p_no_busy_issue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid & bank_busy) == '0);

    p_one_outstanding_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid & outst_q) == '0);

    p_gap_after_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (|iss_valid) |=> (iss_valid & $past(iss_valid)) == '0);

    p_cpl_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cpl & ~outst_q) == '0);

    p_epoch_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        barrier |-> open_ep != EP_LAST);
endmodule

bind pws_sched pws_sched_chk #(
    .DEPTH   (DEPTH),
    .NBANK   (NBANK),
    .EPOCH_W (EPOCH_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .enq_valid (enq_valid),
    .enq_full  (enq_full),
    .barrier   (barrier),
    .bank_busy (bank_busy),
    .cpl       (cpl),
    .iss_valid (iss_valid),
    .cur       (st_q.cur),
    .tail      (st_q.tail)
);

// File: tb/sim_pws_sched.sv
module sim_pws_sched;
    localparam int DEPTH = 8;
    localparam int NBANK = 4;
    localparam int AW    = 16;

    logic                     clk = 1'b0;
    logic                     rst_n = 1'b0;
    logic                     enq_valid = 1'b0;
    logic [AW-1:0]            enq_addr = '0;
    logic [1:0]               enq_bank = '0;
    logic                     enq_vol = 1'b0;
    logic                     enq_full;
    logic                     barrier = 1'b0;
    logic [NBANK-1:0]         bank_busy = '0;
    logic [NBANK-1:0]         cpl = '0;
    logic [NBANK-1:0]         iss_valid;
    logic [NBANK-1:0][AW-1:0] iss_addr;
    logic [NBANK-1:0]         iss_vol;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pws_sched #(.DEPTH(DEPTH), .NBANK(NBANK), .ADDR_W(AW), .EPOCH_W(3)) u0 (
        .clk, .rst_n, .enq_valid, .enq_addr, .enq_bank, .enq_vol, .enq_full,
        .barrier, .bank_busy, .cpl, .iss_valid, .iss_addr, .iss_vol
    );

    typedef struct packed {
        logic       bar;
        logic       ev;
        logic       vol;
        logic [1:0] bank;
        logic [15:0] addr;
        logic [3:0] busy;
        logic [3:0] c;
        logic [3:0] xiss;
        logic [3:0] xvol;
        logic       xfull;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 1'b0, 2'd0, 16'h0010, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // P e0 b0
        '{1'b1, 1'b1, 1'b1, 2'd1, 16'h0020, 4'h0, 4'h0, 4'h1, 4'h0, 1'b0}, // V tagged e0, barrier
        '{1'b0, 1'b1, 1'b0, 2'd1, 16'h0030, 4'h0, 4'h0, 4'h2, 4'h2, 1'b0}, // P e1 b1
        '{1'b0, 1'b1, 1'b1, 2'd2, 16'h0040, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // V e1 b2
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 4'h4, 4'h4, 1'b0}, // later V pulled forward
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h2, 4'h0, 4'h0, 1'b0}, // b1 still outstanding
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0}, // P e1 held by P e0
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h1, 4'h0, 4'h0, 1'b0}, // P e0 completes
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 4'h2, 4'h0, 1'b0}, // P e1 released
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h6, 4'h0, 4'h0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 4'h0, 4'h0, 1'b0},
        '{1'b0, 1'b1, 1'b1, 2'd3, 16'h0050, 4'h8, 4'h0, 4'h0, 4'h0, 1'b0}, // older V b3
        '{1'b0, 1'b1, 1'b0, 2'd3, 16'h0060, 4'h8, 4'h0, 4'h0, 4'h0, 1'b0}, // younger P b3
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 4'h8, 4'h0, 1'b0}, // P wins
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h8, 4'h0, 4'h0, 1'b0},
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h0, 4'h8, 4'h8, 1'b0},
        '{1'b0, 1'b0, 1'b0, 2'd0, 16'h0000, 4'h0, 4'h8, 4'h0, 4'h0, 1'b0}
    };
    localparam string TAG [NV] = '{
        "R1", "R4", "R9", "R3", "R5", "R3", "R4", "R10", "R4",
        "R10", "R10", "R3", "R3", "R6", "R10", "R6", "R10"
    };

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic step(input logic bar, input logic ev, input logic vol,
                        input logic [1:0] bk, input logic [15:0] ad,
                        input logic [3:0] busy, input logic [3:0] c);
        @(negedge clk);
        barrier   = bar;
        enq_valid = ev;
        enq_vol   = vol;
        enq_bank  = bk;
        enq_addr  = ad;
        bank_busy = busy;
        cpl       = c;
        #2;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 4'h0);
    endtask

    initial begin
        #(200000 * 10);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n_iss;
        int n_bad;
        logic [3:0] prev;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        // R1: empty after reset
        check("R1", "full after reset", 32'(enq_full), 32'd0);
        check("R1", "issue after reset", 32'(iss_valid), 32'd0);

        // table walk: epochs, pull-forward, priority, outstanding limits
        for (int k = 0; k < NV; k++) begin
            step(TBL[k].bar, TBL[k].ev, TBL[k].vol, TBL[k].bank, TBL[k].addr,
                 TBL[k].busy, TBL[k].c);
            check(TAG[k], $sformatf("row %0d iss_valid", k), 32'(iss_valid), 32'(TBL[k].xiss));
            check(TAG[k], $sformatf("row %0d iss_vol", k), 32'(iss_vol & iss_valid), 32'(TBL[k].xvol));
            check(TAG[k], $sformatf("row %0d full", k), 32'(enq_full), 32'(TBL[k].xfull));
        end

        // R7: oldest first within one bank and class
        step(1'b0, 1'b1, 1'b1, 2'd0, 16'h0100, 4'h1, 4'h0);
        step(1'b0, 1'b1, 1'b1, 2'd0, 16'h0101, 4'h1, 4'h0);
        idle();
        check("R7", "first volatile addr", 32'(iss_addr[0]), 32'h0100);
        check("R10", "lane0 class volatile", 32'({iss_valid[0], iss_vol[0]}), 32'b11);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 4'h1);
        idle();
        check("R7", "second volatile addr", 32'({iss_valid[0], iss_addr[0]}), {15'd0, 1'b1, 16'h0101});
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 4'h1);

        // R8: same address keeps arrival order over class priority
        step(1'b0, 1'b1, 1'b1, 2'd2, 16'h0300, 4'h4, 4'h0);
        step(1'b0, 1'b1, 1'b0, 2'd2, 16'h0300, 4'h4, 4'h0);
        idle();
        check("R8", "older volatile first", 32'({iss_valid[2], iss_vol[2]}), 32'b11);
        check("R8", "addr of first", 32'(iss_addr[2]), 32'h0300);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 4'h4);
        idle();
        check("R8", "persistent second", 32'({iss_valid[2], iss_vol[2]}), 32'b10);
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 4'h4);

        // R9: barrier with nothing pending adds no delay
        step(1'b1, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 4'h0);
        step(1'b0, 1'b1, 1'b0, 2'd1, 16'h0400, 4'h0, 4'h0);
        idle();
        check("R9", "persistent after empty barrier", 32'({iss_valid[1], iss_addr[1]}),
              {15'd0, 1'b1, 16'h0400});
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, 4'h2);

        // R2: fill, refuse, drain
        for (int i = 0; i < DEPTH; i++) begin
            step(1'b0, 1'b1, 1'b0, 2'(i % NBANK), 16'h0500 + 16'(i), 4'hF, 4'h0);
        end
        step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'hF, 4'h0);
        check("R2", "full after DEPTH entries", 32'(enq_full), 32'd1);
        step(1'b0, 1'b1, 1'b0, 2'd0, 16'h0999, 4'hF, 4'h0);
        n_iss = 0;
        n_bad = 0;
        prev  = '0;
        for (int t = 0; t < 40; t++) begin
            step(1'b0, 1'b0, 1'b0, 2'd0, 16'h0, 4'h0, prev);
            for (int b = 0; b < NBANK; b++) begin
                if (iss_valid[b]) begin
                    n_iss++;
                    if (iss_addr[b] == 16'h0999) n_bad++;
                end
            end
            prev = iss_valid;
        end
        check("R2", "writes drained", 32'(n_iss), 32'd8);
        check("R2", "refused entry issued", 32'(n_bad), 32'd0);
        check("R10", "full cleared by completions", 32'(enq_full), 32'd0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule